// File: doc/BRIEF.md
# Binary Pixel Hit Buffer with Token Readout

This block is the digital back end of a binary pixel sensor array used in a pulsed-beam detector. The beam arrives in trains of closely spaced crossings (a few thousand over about a millisecond), and each train is followed by a long idle gap. During a train, the one-bit comparator output of every pixel is sampled on each crossing. When a pixel fires, the current crossing number from an external counter is stored in that pixel's own small buffer. The buffer fills in slot order. If a pixel fires again after all of its slots are full, a sticky overflow mark is set in place of a new record.

When the train ends, a token starts at pixel 0 and moves up the chain. Each pixel that holds records places them on the shared output in turn: one word per cycle, made of the pixel's fixed identifier and one stored crossing number. A pixel with no records holds the token for exactly one cycle and emits nothing. A done flag rises when the token leaves the last pixel. The flag stays high until the next train begins, and that train start also clears every buffer.

Top module: `bxpix_readout`

## Requirements
- R1: After reset, `hs_valid`, `hs_ovf` and `rd_done` are 0.
- R2: On a cycle where a train is running, and neither `train_start` nor `train_end` is high, a pixel whose `comp` bit is 1 stores the value of `bx` in its lowest free slot. At readout, that pixel's words come out slot 0 first, so its hits appear in arrival order.
- R3: Each pixel keeps at most NSLOT (default 2) records. A hit that finds all slots full sets the pixel's overflow mark and changes no record. `hs_ovf` is 1 only on the final word of a pixel whose mark is set.
- R4: Words appear only after the train has ended. Pixels are visited in ascending index order. `hs_pix` equals ID_BASE (default 0x20) plus the pixel index.
- R5: Each readout step takes one cycle. A pixel costs one step per stored record, or a single step if it holds none. `rd_done` rises on the same edge that registers the final step, which is the (S+1)-th falling edge after the edge that samples `train_end`, where S is the sum of the step costs of all pixels.
- R6: A `comp` bit is ignored when no train is running (this includes the readout phase), and also on the cycle where `train_start` or `train_end` is sampled high.
- R7: `train_start` clears every record and overflow mark. It also cancels a readout in progress: after that edge, `rd_done` and `hs_valid` are 0.
- R8: `train_end` has no effect while no train is running.
- R9: Once `rd_done` is 1, it stays 1 and no further words appear until the next `train_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_start | input | 1 | One-cycle pulse: clear buffers and begin a train |
| train_end | input | 1 | One-cycle pulse: stop recording and begin readout |
| bx | input | TS_W | Current crossing number |
| comp | input | NPIX | Comparator bit of each pixel, sampled every cycle |
| hs_valid | output | 1 | An output word is present this cycle |
| hs_pix | output | ID_W | Identifier of the pixel that owns the word |
| hs_bx | output | TS_W | Stored crossing number |
| hs_ovf | output | 1 | Owning pixel overflowed (set on its last word only) |
| rd_done | output | 1 | Token has passed the last pixel |

## Verification
The main check walks a table of comparator masks through one train. The table mixes single-pixel hits, a pixel that fires four times, a block of neighbouring pixels, and a final all-ones crossing. This separates correct slot filling and ordering from overflow marking, and both from the visiting order along the token chain. An empty train tests the fixed one-step cost of empty pixels, with no data present to hide it. A train with hits driven on its start and end cycles, and all-ones comparator noise driven during readout, tells the recording window apart from any off-by-one widening of it. A train restarted in the middle of readout shows whether the restart discards the old records and cancels the partly finished pass.

// File: rtl/bxpix_pkg.sv
package bxpix_pkg;

  // Identifier that a pixel's read-only word holds.
  function automatic logic [31:0] pix_ident(input int unsigned base, input int unsigned idx);
    return 32'(base + idx);
  endfunction

  // One-hot select of the lowest empty slot (0 when all are full).
  function automatic logic [31:0] first_free_sel(input logic [31:0] valid, input int unsigned n);
    for (int unsigned i = 0; i < n; i++)
      if (!valid[i]) return 32'(1) << i;
    return '0;
  endfunction

  // Readout cycles spent on a pixel holding nrec records.
  function automatic int unsigned step_cost(input int unsigned nrec);
    return (nrec == 0) ? 1 : nrec;
  endfunction

endpackage

// File: rtl/bxpix_cell.sv
module bxpix_cell
  import bxpix_pkg::*;
#(
  parameter int TS_W  = 12,
  parameter int NSLOT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        rec_en,
  input  logic                        hit,
  input  logic [TS_W-1:0]             ts_in,
  output logic [NSLOT-1:0]            valid,
  output logic [NSLOT-1:0][TS_W-1:0]  ts,
  output logic                        ovf,
  output logic                        wr_ev
);
  logic [31:0]      sel_w;
  logic [NSLOT-1:0] sel;
  logic             ovf_ev;

  assign sel_w  = first_free_sel(32'(valid), NSLOT);
  assign sel    = sel_w[NSLOT-1:0];
  assign wr_ev  = rec_en & hit & (|sel);
  assign ovf_ev = rec_en & hit & ~(|sel);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      valid <= '0;
      ts    <= '0;
      ovf   <= 1'b0;
    end else begin
      if (wr_ev) begin
        for (int s = 0; s < NSLOT; s++) begin
          if (sel[s]) begin
            valid[s] <= 1'b1;
            ts[s]    <= ts_in;
          end
        end
      end
      if (ovf_ev) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/bxpix_token.sv
module bxpix_token #(
  parameter int NPIX  = 16,
  parameter int NSLOT = 2,
  localparam int SL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [NSLOT-1:0] cur_valid,
  output logic [NPIX-1:0]  tok,
  output logic [SL_W-1:0]  slot,
  output logic             active,
  output logic             done,
  output logic             emit,
  output logic             pix_last
);
  logic [NSLOT:0] vext;
  logic [SL_W:0]  nxt;
  logic           leave;

  assign vext     = {1'b0, cur_valid};
  assign nxt      = {1'b0, slot} + 1'b1;
  assign emit     = active & cur_valid[slot];
  assign pix_last = active & (~cur_valid[slot] | ~vext[nxt]);
  assign leave    = pix_last & tok[NPIX-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tok    <= '0;
      slot   <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else if (load) begin
      tok    <= NPIX'(1);
      slot   <= '0;
      active <= 1'b1;
      done   <= 1'b0;
    end else if (active) begin
      if (pix_last) begin
        slot <= '0;
        tok  <= tok << 1;
        if (leave) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bxpix_emit.sv
module bxpix_emit #(
  parameter int ID_W = 8,
  parameter int TS_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            emit,
  input  logic [ID_W-1:0] id,
  input  logic [TS_W-1:0] ts,
  input  logic            ovf_last,
  output logic            o_valid,
  output logic [ID_W-1:0] o_id,
  output logic [TS_W-1:0] o_ts,
  output logic            o_ovf
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      o_valid <= 1'b0;
      o_id    <= '0;
      o_ts    <= '0;
      o_ovf   <= 1'b0;
    end else begin
      o_valid <= emit;
      o_ovf   <= emit & ovf_last;
      if (emit) begin
        o_id <= id;
        o_ts <= ts;
      end
    end
  end
endmodule

// File: rtl/bxpix_readout.sv
module bxpix_readout
  import bxpix_pkg::*;
#(
  parameter int NPIX    = 16,
  parameter int NSLOT   = 2,
  parameter int TS_W    = 12,
  parameter int ID_W    = 8,
  parameter int ID_BASE = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            train_start,
  input  logic            train_end,
  input  logic [TS_W-1:0] bx,
  input  logic [NPIX-1:0] comp,
  output logic            hs_valid,
  output logic [ID_W-1:0] hs_pix,
  output logic [TS_W-1:0] hs_bx,
  output logic            hs_ovf,
  output logic            rd_done
);
  localparam int PIX_W = (NPIX > 1) ? $clog2(NPIX) : 1;
  localparam int SL_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic                                  in_train;
  logic                                  rec_en;
  logic                                  rd_load;
  logic [NPIX-1:0][NSLOT-1:0]            pv;
  logic [NPIX-1:0][NSLOT-1:0][TS_W-1:0]  pts;
  logic [NPIX-1:0]                       povf;
  logic [NPIX-1:0]                       wr_ev;
  logic                                  wr_any;
  logic [NPIX-1:0]                       tok;
  logic [SL_W-1:0]                       slot;
  logic                                  tok_active;
  logic                                  emit;
  logic                                  pix_last;
  logic [PIX_W-1:0]                      cur_pix;
  logic [ID_W-1:0]                       cur_id;

  // Train window
  assign rec_en  = in_train & ~train_start & ~train_end;
  assign rd_load = in_train & train_end & ~train_start;

  always_ff @(posedge clk) begin
    if (!rst_n)           in_train <= 1'b0;
    else if (train_start) in_train <= 1'b1;
    else if (train_end)   in_train <= 1'b0;
  end

  // Per-pixel buffers
  for (genvar g = 0; g < NPIX; g++) begin : g_pix
    bxpix_cell #(.TS_W(TS_W), .NSLOT(NSLOT)) u_cell (
      .clk(clk), .rst_n(rst_n), .clr(train_start), .rec_en(rec_en),
      .hit(comp[g]), .ts_in(bx), .valid(pv[g]), .ts(pts[g]),
      .ovf(povf[g]), .wr_ev(wr_ev[g])
    );
  end
  assign wr_any = |wr_ev;

  // Token holder index
  always_comb begin
    cur_pix = '0;
    for (int p = 0; p < NPIX; p++)
      if (tok[p]) cur_pix = PIX_W'(p);
  end
  assign cur_id = ID_W'(pix_ident(ID_BASE, 32'(cur_pix)));

  bxpix_token #(.NPIX(NPIX), .NSLOT(NSLOT)) u_tok (
    .clk(clk), .rst_n(rst_n), .clr(train_start), .load(rd_load),
    .cur_valid(pv[cur_pix]), .tok(tok), .slot(slot), .active(tok_active),
    .done(rd_done), .emit(emit), .pix_last(pix_last)
  );

  bxpix_emit #(.ID_W(ID_W), .TS_W(TS_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(train_start), .emit(emit),
    .id(cur_id), .ts(pts[cur_pix][slot]), .ovf_last(povf[cur_pix] & pix_last),
    .o_valid(hs_valid), .o_id(hs_pix), .o_ts(hs_bx), .o_ovf(hs_ovf)
  );
endmodule

// File: rtl/bxpix_chk.sv
module bxpix_chk #(
  parameter int NPIX = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            train_start,
  input logic            train_end,
  input logic            in_train,
  input logic            wr_any,
  input logic [NPIX-1:0] tok,
  input logic            tok_active,
  input logic            hs_valid,
  input logic            hs_ovf,
  input logic            rd_done
);
  // R6
  rec_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |-> (in_train && !train_start && !train_end));

  // R4
  out_after_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> !in_train);

  // R3
  ovf_on_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ovf |-> hs_valid);

  // R5
  tok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok));

  // R5
  tok_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_active |-> ($countones(tok) == 1));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !train_start) |=> (rd_done && !hs_valid));

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_start |=> (!rd_done && !hs_valid && in_train));
endmodule

bind bxpix_readout bxpix_chk #(.NPIX(NPIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
  .in_train(in_train), .wr_any(wr_any), .tok(tok), .tok_active(tok_active),
  .hs_valid(hs_valid), .hs_ovf(hs_ovf), .rd_done(rd_done)
);

// File: tb/sim_bxpix_readout.sv
`timescale 1ns/1ps
module sim_bxpix_readout;
  localparam int NPIX = 16, NSLOT = 2, TS_W = 12, ID_W = 8, ID_BASE = 32;
  localparam int NROW = 8;
  localparam int EXP_WORDS = 22;  // hand count for the table train
  localparam logic [NPIX-1:0] ROWS [NROW] = '{
    16'h0001, 16'h8001, 16'h0001, 16'h0001,
    16'h0F00, 16'h0000, 16'h0100, 16'hFFFF };

  logic clk = 0, rst_n = 0, train_start = 0, train_end = 0;
  logic [TS_W-1:0] bx = '0;
  logic [NPIX-1:0] comp = '0;
  logic hs_valid, hs_ovf, rd_done;
  logic [ID_W-1:0] hs_pix;
  logic [TS_W-1:0] hs_bx;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model
  bit mv [NPIX][NSLOT];
  int mts [NPIX][NSLOT];
  bit movf [NPIX];
  int exp_id [64], exp_ts [64];
  bit exp_ov [64];
  int nexp, steps;

  always #2 clk = ~clk;

  bxpix_readout #(.NPIX(NPIX), .NSLOT(NSLOT), .TS_W(TS_W), .ID_W(ID_W), .ID_BASE(ID_BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
    .bx(bx), .comp(comp), .hs_valid(hs_valid), .hs_pix(hs_pix), .hs_bx(hs_bx),
    .hs_ovf(hs_ovf), .rd_done(rd_done));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int p = 0; p < NPIX; p++) begin
      movf[p] = 0;
      for (int s = 0; s < NSLOT; s++) begin mv[p][s] = 0; mts[p][s] = 0; end
    end
  endtask

  task automatic model_hit(input logic [NPIX-1:0] m, input int t);
    for (int p = 0; p < NPIX; p++) begin
      if (m[p]) begin
        bit placed = 0;
        for (int s = 0; s < NSLOT; s++)
          if (!placed && !mv[p][s]) begin mv[p][s] = 1; mts[p][s] = t; placed = 1; end
        if (!placed) movf[p] = 1;
      end
    end
  endtask

  task automatic build_expect();
    nexp = 0; steps = 0;
    for (int p = 0; p < NPIX; p++) begin
      int n = 0;
      for (int s = 0; s < NSLOT; s++) if (mv[p][s]) n++;
      steps += (n == 0) ? 1 : n;
      for (int s = 0; s < n; s++) begin
        exp_id[nexp] = ID_BASE + p;
        exp_ts[nexp] = mts[p][s];
        exp_ov[nexp] = movf[p] && (s == n - 1);
        nexp++;
      end
    end
  endtask

  task automatic start_train(input logic [NPIX-1:0] c);
    @(posedge clk); #1 train_start = 1; comp = c;
    @(posedge clk); #1 train_start = 0; comp = '0;
  endtask

  task automatic drive_row(input logic [NPIX-1:0] m, input int t);
    comp = m; bx = TS_W'(t); model_hit(m, t);
    @(posedge clk); #1 comp = '0;
  endtask

  task automatic end_train(input logic [NPIX-1:0] c);
    train_end = 1; comp = c;
    @(posedge clk); #1 train_end = 0; comp = '0;
  endtask

  // Collect one readout pass; called just after the edge sampling train_end.
  task automatic do_readout(input string req, input bit noise);
    int cnt = 0, k = 0;
    bit fin = 0;
    while (!fin && cnt < 200) begin
      @(negedge clk); cnt++;
      if (noise) comp = '1;
      if (hs_valid) begin
        if (k < nexp) begin
          chk(hs_pix == exp_id[k], req, "pixel id", hs_pix, exp_id[k]);
          chk(hs_bx == exp_ts[k], req, "crossing", hs_bx, exp_ts[k]);
          chk(hs_ovf == exp_ov[k], {req, " R3"}, "overflow mark", hs_ovf, exp_ov[k]);
        end
        k++;
      end
      if (rd_done) fin = 1;
    end
    comp = '0;
    chk(fin, {req, " R5"}, "done seen", fin, 1);
    chk(k == nexp, {req, " R4"}, "word count", k, nexp);
    chk(cnt == steps + 1, {req, " R5"}, "done latency", cnt, steps + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(hs_valid == 0, "R1", "hs_valid", hs_valid, 0);
    chk(hs_ovf == 0, "R1", "hs_ovf", hs_ovf, 0);
    chk(rd_done == 0, "R1", "rd_done", rd_done, 0);

    // Table train: R2 R3 R4 R5, noise during readout checks R6
    model_clear();
    start_train('0);
    for (int i = 0; i < NROW; i++) drive_row(ROWS[i], 100 + i);
    end_train('0);
    build_expect();
    chk(nexp == EXP_WORDS, "R2", "model word count", nexp, EXP_WORDS);
    do_readout("R2 R6", 1);

    // R8 and R9: stray train_end after done
    @(posedge clk); #1 train_end = 1;
    @(posedge clk); #1 train_end = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(rd_done == 1, "R8 R9", "done held", rd_done, 1);
      chk(hs_valid == 0, "R8 R9", "no words", hs_valid, 0);
    end

    // Empty train: every pixel costs one step (R5)
    model_clear();
    start_train('0);
    end_train('0);
    build_expect();
    do_readout("R5 empty", 0);

    // Hits on start and end cycles are ignored (R6)
    model_clear();
    start_train(16'h0010);
    drive_row(16'h0002, 5);
    end_train(16'h0010);
    build_expect();
    do_readout("R6 edges", 0);

    // Restart during readout (R7)
    model_clear();
    start_train('0);
    drive_row(16'hFFFF, 9);
    end_train('0);
    repeat (4) @(negedge clk);
    @(posedge clk); #1 train_start = 1;
    @(posedge clk); #1 train_start = 0;
    @(negedge clk);
    chk(rd_done == 0, "R7", "done cleared", rd_done, 0);
    chk(hs_valid == 0, "R7", "output cleared", hs_valid, 0);
    model_clear();
    @(posedge clk); #1;
    end_train('0);
    build_expect();
    do_readout("R7 restart", 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule